// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block models a synchronous static memory with a built-in four-beat burst engine. Every control, address and data input is sampled on the rising clock edge. A burst begins when one of two address strobes loads an external address: one strobe comes from the processor side and one from the controller side. After that, a 2-bit beat counter produces the next three word addresses, one per clock, whenever the advance input is held low. A mode input picks the stepping order, either linear or interleaved. The counter wraps after the fourth beat.

Each 36-bit word is split into four 9-bit byte lanes. Each lane has 8 data bits and 1 parity bit. A write can update any set of lanes through per-lane write strobes, which count only while a lane-write enable is low. A global write updates all four lanes. Reads flow straight from the array to the output, so the first word is available in the cycle after the address cycle and each following word one clock later (2-1-1-1). The output enable acts without waiting for the clock. The array depth is set by `ADDR_W`. A value of 15 gives the full 32K-word array, and the default is kept small.

Top module: `sram_burst_top`

## Requirements
- R1: The array holds 2**ADDR_W words of 36 bits. Lane n (0..3) is made of data bits [8n+7:8n] and parity bit 32+n.
- R2: On a rising edge with `cstb_n` low, the block stores `addr`, clears the beat counter, and records selection. The device is selected only when `sel_n`=0, `sel2_n`=0 and `sel2`=1. For a read, the first word appears on `q_out` in the following cycle.
- R3: `pstb_n` low loads a burst in the same way as `cstb_n`, but only when `sel_n` is low. With `sel_n` high and `cstb_n` high, `pstb_n` has no effect and the current burst continues unchanged.
- R4: On an edge with no load and an active burst, `adv_n` low steps the burst to the next beat. `adv_n` high holds the current beat.
- R5: With `order_lin`=1, the two low address bits equal the loaded low bits plus the beat number, modulo 4.
- R6: With `order_lin`=0, the two low address bits equal the loaded low bits XOR the beat number.
- R7: After the fourth beat the burst returns to the first address unless a new strobe arrives.
- R8: On an edge with no load and an active burst, lane n takes `d_in` when `wr_all_n` is low, or when `lane_wr_en_n` is low and `lane_wr_n[n]` is low. Other lanes keep their contents. `lane_wr_n` has no effect while `lane_wr_en_n` is high.
- R9: `q_en` is high only when a selected burst is active and `out_en_n` is low. It follows `out_en_n` without a clock. While `q_en` is low, `q_out` is all zeros, which stands for high impedance. A load with the device deselected turns `q_en` off.
- R10: After reset no burst is active and `q_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the burst state |
| addr | input | ADDR_W | External word address |
| pstb_n | input | 1 | Processor-side address strobe, active low |
| cstb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary select, active low; also gates `pstb_n` |
| sel2_n | input | 1 | Second select, active low |
| sel2 | input | 1 | Third select, active high |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Enable for per-lane write strobes, active low |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| d_in | input | 36 | Write data |
| out_en_n | input | 1 | Output enable, active low, unclocked |
| q_out | output | 36 | Read data; zero while not driven |
| q_en | output | 1 | High when `q_out` is driven |

## Verification
The assertions assume that reset is applied before the first strobe and that `order_lin` does not change inside a burst. Its value at the checking edge decides the beat order. The bench changes inputs only at falling edges, and changes the mode only on the clock that loads a new burst. The bench reads back only words that a global write has fully initialised, so partial-lane writes always merge onto known contents.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_INTERLEAVED = 1'b0,
        ORD_LINEAR      = 1'b1
    } burst_order_e;

    // Low address bits for a given beat of a four-beat burst
    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input burst_order_e      order
    );
        if (order == ORD_LINEAR) begin
            return start + beat;
        end
        return start ^ beat;
    endfunction

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              sel_n,
    input  logic              sel2_n,
    input  logic              sel2,
    input  logic              order_lin,
    output logic              active,
    output logic              step,
    output logic [ADDR_W-1:0] cur_addr
);

    typedef struct packed {
        logic              act;
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic load_w;
    logic chip_ok;
    burst_order_e order;

    always_comb begin
        order   = order_lin ? ORD_LINEAR : ORD_INTERLEAVED;
        chip_ok = !sel_n && !sel2_n && sel2;
        load_w  = !cstb_n || (!pstb_n && !sel_n);
        seq_d   = seq_q;
        if (load_w) begin
            seq_d.act  = chip_ok;
            seq_d.base = addr;
            seq_d.cnt  = '0;
        end else if (seq_q.act && !adv_n) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active   = seq_q.act;
    assign step     = seq_q.act && !load_w;
    assign cur_addr = {seq_q.base[ADDR_W-1:BEAT_W],
                       beat_low(seq_q.base[BEAT_W-1:0], seq_q.cnt, order)};

    // R2: a controller strobe restarts the burst at beat zero on the given address
    a_r2_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !cstb_n |=> (seq_q.cnt == '0) && (seq_q.base == $past(addr)));

    // R3: processor strobe without primary select leaves the burst alone
    a_r3_pstb_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && sel_n && cstb_n && adv_n) |=> $stable(seq_q));

    // R4: no strobe and no advance holds the beat
    a_r4_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (pstb_n && cstb_n && adv_n) |=> $stable(seq_q.cnt) && $stable(seq_q.base));

    // R7: the beat after the fourth returns to the first
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.act && pstb_n && cstb_n && !adv_n && seq_q.cnt == 2'd3) |=> (seq_q.cnt == '0));

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                            clk,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [LANES-1:0]                lane_we,
    input  logic [LANES*(LANE_W+1)-1:0]     wdata,
    output logic [LANES*(LANE_W+1)-1:0]     rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;
    localparam int WORD_W = LANES * (LANE_W + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] merged;

    assign rdata = mem[addr];

    // Data bits of lane n sit at n*LANE_W, its parity bit at DATA_W+n
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        assign merged[n*LANE_W +: LANE_W] = lane_we[n] ? wdata[n*LANE_W +: LANE_W]
                                                       : rdata[n*LANE_W +: LANE_W];
        assign merged[DATA_W + n]         = lane_we[n] ? wdata[DATA_W + n]
                                                       : rdata[DATA_W + n];
    end

    always_ff @(posedge clk) begin
        if (|lane_we) begin
            mem[addr] <= merged;
        end
    end

endmodule

// File: rtl/sram_burst_top.sv
module sram_burst_top #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          pstb_n,
    input  logic                          cstb_n,
    input  logic                          adv_n,
    input  logic                          sel_n,
    input  logic                          sel2_n,
    input  logic                          sel2,
    input  logic                          order_lin,
    input  logic                          wr_all_n,
    input  logic                          lane_wr_en_n,
    input  logic [LANES-1:0]              lane_wr_n,
    input  logic [LANES*(LANE_W+1)-1:0]   d_in,
    input  logic                          out_en_n,
    output logic [LANES*(LANE_W+1)-1:0]   q_out,
    output logic                          q_en
);

    localparam int WORD_W = LANES * (LANE_W + 1);

    logic              active;
    logic              step;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] rdata;

    sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .pstb_n    (pstb_n),
        .cstb_n    (cstb_n),
        .adv_n     (adv_n),
        .sel_n     (sel_n),
        .sel2_n    (sel2_n),
        .sel2      (sel2),
        .order_lin (order_lin),
        .active    (active),
        .step      (step),
        .cur_addr  (cur_addr)
    );

    for (genvar n = 0; n < LANES; n++) begin : g_we
        assign lane_we[n] = step && (!wr_all_n || (!lane_wr_en_n && !lane_wr_n[n]));
    end

    sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .addr    (cur_addr),
        .lane_we (lane_we),
        .wdata   (d_in),
        .rdata   (rdata)
    );

    assign q_en  = active && !out_en_n;
    assign q_out = q_en ? rdata : '0;

    // R8: lane strobes are inert without the lane enable or global write
    a_r8_lane_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_all_n && lane_wr_en_n) |-> (lane_we == '0));

    // R9: a high output enable always leaves the outputs undriven
    a_r9_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (!q_en && q_out == '0));

    // R10: an inactive burst never drives the outputs
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !q_en);

endmodule

// File: tb/sram_burst_top_tb.sv
module sram_burst_top_tb_top;

    localparam int AW = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [AW-1:0] addr;
    logic        pstb_n, cstb_n, adv_n, sel_n, sel2_n, sel2, order_lin;
    logic        wr_all_n, lane_wr_en_n, out_en_n;
    logic [3:0]  lane_wr_n;
    logic [35:0] d_in;
    logic [35:0] q_out;
    logic        q_en;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // behavioural reference state
    bit          m_act;
    int          m_base;
    int          m_cnt;
    logic [35:0] ref_mem [int];

    always #4 clk = ~clk;

    sram_burst_top #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .pstb_n(pstb_n), .cstb_n(cstb_n),
        .adv_n(adv_n), .sel_n(sel_n), .sel2_n(sel2_n), .sel2(sel2),
        .order_lin(order_lin), .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n),
        .lane_wr_n(lane_wr_n), .d_in(d_in), .out_en_n(out_en_n),
        .q_out(q_out), .q_en(q_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int m_addr();
        int lo;
        int b;
        b  = m_base & 3;
        lo = order_lin ? ((b + m_cnt) % 4) : (b ^ m_cnt);
        return (m_base & ~3) | lo;
    endfunction

    task automatic compare(input string tag);
        bit exp_en;
        int a;
        exp_en = m_act && !out_en_n;
        chk(q_en == exp_en, tag, {35'd0, q_en}, {35'd0, exp_en});
        if (exp_en) begin
            a = m_addr();
            if (ref_mem.exists(a)) chk(q_out == ref_mem[a], tag, q_out, ref_mem[a]);
        end else begin
            chk(q_out == '0, tag, q_out, 36'd0);
        end
    endtask

    task automatic tick(input string tag);
        bit ld;
        int a;
        logic [35:0] w;
        @(posedge clk);
        ld = !cstb_n || (!pstb_n && !sel_n);
        if (ld) begin
            m_act  = !sel_n && !sel2_n && sel2;
            m_base = int'(addr);
            m_cnt  = 0;
        end else if (m_act) begin
            a = m_addr();
            w = ref_mem.exists(a) ? ref_mem[a] : 36'd0;
            for (int n = 0; n < 4; n++) begin
                if (!wr_all_n || (!lane_wr_en_n && !lane_wr_n[n])) begin
                    w[n*8 +: 8] = d_in[n*8 +: 8];
                    w[32 + n]   = d_in[32 + n];
                end
            end
            if (!wr_all_n || (!lane_wr_en_n && lane_wr_n != 4'hF)) ref_mem[a] = w;
            if (!adv_n) m_cnt = (m_cnt + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        pstb_n = 1; cstb_n = 1; adv_n = 1; sel_n = 0; sel2_n = 0; sel2 = 1;
        wr_all_n = 1; lane_wr_en_n = 1; lane_wr_n = 4'hF; out_en_n = 0;
        addr = '0; d_in = '0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog R10 actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        idle();
        order_lin = 1;
        rst_n = 0;
        m_act = 0; m_base = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R10");
        rst_n = 1;

        // R8 global write, linear burst from 4: fills 4..7
        addr = 10'd4; cstb_n = 0; tick("R2");
        cstb_n = 1; wr_all_n = 0; adv_n = 0;
        for (int i = 0; i < 4; i++) begin
            d_in = {4'(i + 3), 32'hA5A5_0000 + 32'(i * 32'h1111)};
            tick("R8");
        end
        wr_all_n = 1; adv_n = 1; tick("R4");
        tick("R4");

        // R5 linear from 5: 5,6,7,4, then wrap to 5 (R7)
        addr = 10'd5; cstb_n = 0; tick("R2");
        cstb_n = 1; adv_n = 0;
        tick("R5"); tick("R5"); tick("R5"); tick("R7");

        // R6 interleaved from 5: 5,4,7,6, then 5
        order_lin = 0; addr = 10'd5; cstb_n = 0; adv_n = 1; tick("R6");
        cstb_n = 1; adv_n = 0;
        tick("R6"); tick("R6"); tick("R6"); tick("R7");

        // R3 processor strobe without primary select is ignored
        adv_n = 1; pstb_n = 0; sel_n = 1; addr = 10'h100; tick("R3");
        sel_n = 0; addr = 10'd6; order_lin = 1; tick("R3");
        pstb_n = 1; adv_n = 0; tick("R3");

        // R9 deselecting loads
        adv_n = 1; cstb_n = 0; sel2 = 0; addr = 10'd4; tick("R9");
        sel2 = 1; cstb_n = 1; pstb_n = 0; sel2_n = 1; tick("R2");
        pstb_n = 1; sel2_n = 0; tick("R9");

        // R8 lane writes on word 4
        cstb_n = 0; addr = 10'd4; tick("R2");
        cstb_n = 1; lane_wr_en_n = 0; lane_wr_n = 4'b1010; d_in = 36'hF_FFFF_FFFF; tick("R8");
        lane_wr_en_n = 1; lane_wr_n = 4'b0000; d_in = 36'd0; tick("R8");
        tick("R1");
        lane_wr_en_n = 0; lane_wr_n = 4'b0111; d_in = 36'h8_7700_0000; tick("R1");
        lane_wr_en_n = 1; lane_wr_n = 4'hF; wr_all_n = 0; d_in = 36'h1_2345_6789; tick("R8");
        wr_all_n = 1; tick("R8");

        // R9 output enable acts without a clock
        out_en_n = 1; #1; compare("R9");
        out_en_n = 0; #1; compare("R9");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule